// File: doc/BRIEF.md
# Quad SPI Host Register and FIFO Front End

This block is the memory-mapped front of a quad SPI host controller. It sits between a simple single-cycle register bus and the serial frame sequencer. It holds the control word, the frame setup (total bytes, command bytes, idle clocks), the interrupt enables and a status word. It also owns the transmit and receive byte FIFOs. Each FIFO can be reached one byte per access, or four bytes per access through a packed port. A control flag gates the packed ports.

A write to the frame setup register starts a frame, but only while the controller is enabled. The sequencer pulls transmit bytes with a take strobe and pushes received bytes with a push strobe, marking the last byte of the frame. It reports transmit completion with a pulse. Event bits latch these happenings until software writes ones to them. A level interrupt is the OR of the enabled status bits.

Bus reads return data on `bus_rdata` one cycle after the request. The value is held until the next read. Registers sit at byte addresses: control 0x00, frame setup 0x04, upper total bytes 0x08, interrupt enable 0x0C, status 0x10, byte RX 0x20, byte TX 0x24, packed RX 0x28, packed TX 0x2C.

Top module: `qspi_regfront`

## Requirements
- R1: After reset, control, interrupt enable, frame fields and all event bits are zero, both FIFOs are empty, `irq` and `seq_start` are low, and a status read returns 0x018 with bit 7 copying `seq_ready`.
- R2: Control (0x00, bits [11:0]), interrupt enable (0x0C, bits [5:0]) and upper total bytes (0x08, bits [15:0]) read back what was written. The control word drives `seq_ctrl`: bit 0 enables, bit 1 selects host mode, bit 2 selects packed access, and bits [11:3] pass through uninterpreted.
- R3: A write to 0x04 latches total-low [15:0], command bytes [24:16] and idle clocks [28:25]. The frame fields read back in that layout. `seq_total` joins the upper register above total-low. If control bit 0 was set before the write, `seq_start` is high for exactly the following cycle; otherwise it stays low.
- R4: The status word has these bits:
  - bit 0: TX done
  - bit 1: RX done
  - bit 2: RX available
  - bit 3: TX has at least four free slots
  - bit 4: RX FIFO empty
  - bit 5: TX FIFO full
  - bit 7: `seq_ready`
  - bit 8: packed flag
  - bit 9: sticky TX overflow
  - bit 6 and bits above 9 read as zero.
- R5: Bits 0, 1, 2 and 9 of status are cleared by writing 1 to 0x10, and writing 0 leaves them alone. A set event in the same cycle as a clear wins.
- R6: `irq` equals the OR over bits 0..5 of status AND interrupt enable.
- R7: A write to 0x24 pushes wdata[7:0] unless the TX FIFO is full. When full, the byte is dropped and status bit 9 is set.
- R8: With the packed flag set, a write to 0x2C pushes four bytes, wdata[7:0] first and wdata[31:24] last. If fewer than four slots are free, nothing is pushed and bit 9 is set. With the flag clear, the write is ignored.
- R9: A read of 0x20 pops one byte and returns it in [7:0] with upper bits zero. An empty FIFO returns zero.
- R10: With the packed flag set, a read of 0x28 pops up to four bytes, the oldest in [7:0], with absent bytes zero. With the flag clear, it returns zero and pops nothing.
- R11: RX available sets when a pushed byte enters an empty RX FIFO. RX done sets when the byte marked last enters. TX done sets on `seq_tx_done`.
- R12: `seq_tx_valid` is high while the TX FIFO holds data and `seq_tx_data` shows the oldest byte. `seq_tx_take` removes it, and may coincide with a bus push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |
| seq_ctrl | output | 12 | Control word to the sequencer |
| seq_total | output | 32 | Total frame bytes |
| seq_cmd_bytes | output | 9 | Command bytes of the frame |
| seq_idle_clks | output | 4 | Idle clocks of the frame |
| seq_start | output | 1 | One-cycle frame start |
| seq_tx_valid | output | 1 | TX byte available |
| seq_tx_data | output | 8 | Oldest TX byte |
| seq_tx_take | input | 1 | Sequencer consumes a TX byte |
| seq_rx_push | input | 1 | Sequencer delivers a received byte |
| seq_rx_data | input | 8 | Received byte |
| seq_rx_last | input | 1 | Delivered byte is the last of the frame |
| seq_tx_done | input | 1 | Transmit part of the frame finished |
| seq_ready | input | 1 | Sequencer idle |

## Verification
Two collisions are the hazards here. The first is a write-one-to-clear of RX done in the same cycle that the sequencer pushes the byte marked last. The second is a bus push into the TX FIFO in the same cycle that the sequencer takes a byte. The bench drives both deliberately, and repeats them at random in a long mixed run, against a behavioural model built on queues. After each clock it compares `irq`, the TX head, the frame outputs and any read data: the event must survive the clear, and no byte may be lost or reordered.

// File: rtl/qspi_regfront_pkg.sv
// Package: register word indices and status bit positions shared by the
// front end modules. Assumes byte addresses with word index in addr[6:2].
package qspi_regfront_pkg;
    localparam int ADDR_W = 7;
    localparam int WIDX_W = 5;

    localparam logic [WIDX_W-1:0] W_CTRL    = 5'h00;
    localparam logic [WIDX_W-1:0] W_FRAME   = 5'h01;
    localparam logic [WIDX_W-1:0] W_FRAMEHI = 5'h02;
    localparam logic [WIDX_W-1:0] W_IEN     = 5'h03;
    localparam logic [WIDX_W-1:0] W_STAT    = 5'h04;
    localparam logic [WIDX_W-1:0] W_RXB     = 5'h08;
    localparam logic [WIDX_W-1:0] W_TXB     = 5'h09;
    localparam logic [WIDX_W-1:0] W_RXW     = 5'h0A;
    localparam logic [WIDX_W-1:0] W_TXW     = 5'h0B;

    localparam int CTRL_W   = 12;
    localparam int IEN_W    = 6;
    localparam int STAT_W   = 10;

    localparam int C_EN     = 0;
    localparam int C_HOST   = 1;
    localparam int C_PACK   = 2;

    localparam int S_TXDONE = 0;
    localparam int S_RXDONE = 1;
    localparam int S_RXAV   = 2;
    localparam int S_OVF    = 9;

    // event register layout inside the status block
    typedef struct packed {
        logic ovf;
        logic rxav;
        logic rxdone;
        logic txdone;
    } evt_t;
endpackage

// File: rtl/qspi_byte_fifo.sv
// Byte FIFO accepting up to four pushes and four pops per cycle.
// Assumes DEPTH is a power of two, at least 4, and that the caller never
// pushes beyond free space nor pops beyond the current count.
module qspi_byte_fifo #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [CW-1:0] count,
    output logic [31:0]   head
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // storage write: lane k lands at wr_ptr+k when k < push_n
    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (3'(k) < push_n) begin
                mem[wr_ptr + PW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // four oldest entries, oldest in the low byte
    for (genvar k = 0; k < 4; k++) begin : g_head
        assign head[8*k +: 8] = mem[rd_ptr + PW'(k)];
    end

    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(count) + 32'(push_n) - 32'(pop_n) <= DEPTH) && (32'(pop_n) <= 32'(count)));

    a_r12_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 3'd0 || pop_n != 3'd0) |=>
        count == $past(count) + CW'($past(push_n)) - CW'($past(pop_n)));
endmodule

// File: rtl/qspi_status_irq.sv
// Status word assembly, write-one-to-clear event bits and interrupt level.
// Assumes set inputs are single-cycle event strobes; a set beats a clear.
module qspi_status_irq
    import qspi_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              clr,
    input  evt_t              set,
    input  logic              tx_space4,
    input  logic              rx_empty,
    input  logic              tx_full,
    input  logic              ready,
    input  logic              pack_mode,
    input  logic [IEN_W-1:0]  ien,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    evt_t ev;

    // event latch: clear by mask, then OR in fresh events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev <= '0;
        end else begin
            ev <= (ev & ~clr) | set;
        end
    end

    // assemble the visible status word
    always_comb begin
        status           = '0;
        status[S_TXDONE] = ev.txdone;
        status[S_RXDONE] = ev.rxdone;
        status[S_RXAV]   = ev.rxav;
        status[3]        = tx_space4;
        status[4]        = rx_empty;
        status[5]        = tx_full;
        status[7]        = ready;
        status[8]        = pack_mode;
        status[S_OVF]    = ev.ovf;
    end

    // level interrupt from enabled low status bits
    assign irq = |(status[IEN_W-1:0] & ien);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set.rxdone |=> status[S_RXDONE]);

    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr.rxdone && !set.rxdone |=> !status[S_RXDONE]);

    a_r11_txdone_latch: assert property (@(posedge clk) disable iff (!rst_n)
        set.txdone |=> status[S_TXDONE]);
endmodule

// File: rtl/qspi_regfront.sv
// Register decode, frame setup, byte/packed FIFO access and sequencer
// streams for a quad SPI host. Assumes a single-cycle request bus; reads
// return data the next cycle. The sequencer never pushes into a full RX
// FIFO, and takes TX bytes only while seq_tx_valid is high.
module qspi_regfront
    import qspi_regfront_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TCW = $clog2(TX_DEPTH + 1),
    localparam int RCW = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [11:0]       seq_ctrl,
    output logic [31:0]       seq_total,
    output logic [8:0]        seq_cmd_bytes,
    output logic [3:0]        seq_idle_clks,
    output logic              seq_start,
    output logic              seq_tx_valid,
    output logic [7:0]        seq_tx_data,
    input  logic              seq_tx_take,
    input  logic              seq_rx_push,
    input  logic [7:0]        seq_rx_data,
    input  logic              seq_rx_last,
    input  logic              seq_tx_done,
    input  logic              seq_ready
);
    logic [WIDX_W-1:0] widx;
    logic              wr;
    logic              rd;
    logic [CTRL_W-1:0] ctrl_q;
    logic [IEN_W-1:0]  ien_q;
    logic [15:0]       tot_hi_q;
    logic [15:0]       tot_lo_q;
    logic [8:0]        cmd_q;
    logic [3:0]        idle_q;
    logic              start_q;
    logic [31:0]       rdata_q;

    logic [TCW-1:0]    tx_cnt;
    logic [31:0]       tx_head;
    logic [2:0]        tx_push_n;
    logic [31:0]       tx_push_d;
    logic [2:0]        tx_pop_n;
    logic              txb_wr, txw_wr, txb_ok, txw_ok;

    logic [RCW-1:0]    rx_cnt;
    logic [31:0]       rx_head;
    logic [2:0]        rx_push_n;
    logic [2:0]        rx_pop_n;
    logic [2:0]        rx_avail_n;
    logic              rxb_rd, rxw_rd, rx_push_ok;
    logic [31:0]       rx_packed;

    evt_t              ev_clr;
    evt_t              ev_set;
    logic [STAT_W-1:0] status;
    logic              frame_wr;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign wr       = bus_req && bus_we;
    assign rd       = bus_req && !bus_we;
    assign frame_wr = wr && widx == W_FRAME;

    // configuration registers and frame start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ien_q    <= '0;
            tot_hi_q <= '0;
            tot_lo_q <= '0;
            cmd_q    <= '0;
            idle_q   <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= frame_wr && ctrl_q[C_EN];
            if (wr && widx == W_CTRL)    ctrl_q   <= bus_wdata[CTRL_W-1:0];
            if (wr && widx == W_IEN)     ien_q    <= bus_wdata[IEN_W-1:0];
            if (wr && widx == W_FRAMEHI) tot_hi_q <= bus_wdata[15:0];
            if (frame_wr) begin
                tot_lo_q <= bus_wdata[15:0];
                cmd_q    <= bus_wdata[24:16];
                idle_q   <= bus_wdata[28:25];
            end
        end
    end

    // TX side: byte or packed push from the bus, single pop by the sequencer
    assign txb_wr = wr && widx == W_TXB;
    assign txw_wr = wr && widx == W_TXW && ctrl_q[C_PACK];
    assign txb_ok = txb_wr && (tx_cnt != TCW'(TX_DEPTH));
    assign txw_ok = txw_wr && (32'(tx_cnt) + 32'd4 <= TX_DEPTH);

    always_comb begin
        tx_push_n = 3'd0;
        tx_push_d = bus_wdata;
        if (txb_ok) tx_push_n = 3'd1;
        else if (txw_ok) tx_push_n = 3'd4;
    end

    assign tx_pop_n = {2'b00, seq_tx_take && (tx_cnt != '0)};

    qspi_byte_fifo #(.DEPTH(TX_DEPTH)) u_txf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_d),
        .pop_n     (tx_pop_n),
        .count     (tx_cnt),
        .head      (tx_head)
    );

    // RX side: single push by the sequencer, byte or packed pop from the bus
    assign rx_push_ok = seq_rx_push && (rx_cnt != RCW'(RX_DEPTH));
    assign rx_push_n  = {2'b00, rx_push_ok};
    assign rxb_rd     = rd && widx == W_RXB;
    assign rxw_rd     = rd && widx == W_RXW && ctrl_q[C_PACK];
    assign rx_avail_n = (32'(rx_cnt) >= 32'd4) ? 3'd4 : 3'(rx_cnt);

    always_comb begin
        rx_pop_n = 3'd0;
        if (rxb_rd) rx_pop_n = {2'b00, rx_cnt != '0};
        else if (rxw_rd) rx_pop_n = rx_avail_n;
    end

    // packed RX word with absent lanes forced to zero
    for (genvar k = 0; k < 4; k++) begin : g_rxpack
        assign rx_packed[8*k +: 8] = (3'(k) < rx_avail_n) ? rx_head[8*k +: 8] : 8'h00;
    end

    qspi_byte_fifo #(.DEPTH(RX_DEPTH)) u_rxf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data ({24'h0, seq_rx_data}),
        .pop_n     (rx_pop_n),
        .count     (rx_cnt),
        .head      (rx_head)
    );

    // event clear mask and event sources
    always_comb begin
        ev_clr = '0;
        if (wr && widx == W_STAT) begin
            ev_clr.txdone = bus_wdata[S_TXDONE];
            ev_clr.rxdone = bus_wdata[S_RXDONE];
            ev_clr.rxav   = bus_wdata[S_RXAV];
            ev_clr.ovf    = bus_wdata[S_OVF];
        end
        ev_set.txdone = seq_tx_done;
        ev_set.rxdone = rx_push_ok && seq_rx_last;
        ev_set.rxav   = rx_push_ok && (rx_cnt == '0);
        ev_set.ovf    = (txb_wr && !txb_ok) || (txw_wr && !txw_ok);
    end

    qspi_status_irq u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ev_clr),
        .set       (ev_set),
        .tx_space4 (32'(tx_cnt) + 32'd4 <= TX_DEPTH),
        .rx_empty  (rx_cnt == '0),
        .tx_full   (tx_cnt == TCW'(TX_DEPTH)),
        .ready     (seq_ready),
        .pack_mode (ctrl_q[C_PACK]),
        .ien       (ien_q),
        .status    (status),
        .irq       (irq)
    );

    // read data register, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            case (widx)
                W_CTRL:    rdata_q <= {20'h0, ctrl_q};
                W_FRAME:   rdata_q <= {3'b000, idle_q, cmd_q, tot_lo_q};
                W_FRAMEHI: rdata_q <= {16'h0, tot_hi_q};
                W_IEN:     rdata_q <= {26'h0, ien_q};
                W_STAT:    rdata_q <= {22'h0, status};
                W_RXB:     rdata_q <= {24'h0, (rx_cnt != '0) ? rx_head[7:0] : 8'h00};
                W_RXW:     rdata_q <= ctrl_q[C_PACK] ? rx_packed : 32'h0;
                default:   rdata_q <= 32'h0;
            endcase
        end
    end

    assign bus_rdata     = rdata_q;
    assign seq_ctrl      = ctrl_q;
    assign seq_total     = {tot_hi_q, tot_lo_q};
    assign seq_cmd_bytes = cmd_q;
    assign seq_idle_clks = idle_q;
    assign seq_start     = start_q;
    assign seq_tx_valid  = tx_cnt != '0;
    assign seq_tx_data   = tx_head[7:0];

    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr && !ctrl_q[C_EN] |=> !seq_start);

    a_r8_drop_keeps_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        txw_wr && !txw_ok |=> tx_cnt == $past(tx_cnt) - TCW'($past(tx_pop_n)));

    a_r11_rxav_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_ok && rx_cnt == '0 |=> status[S_RXAV]);

    a_r12_take_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        seq_tx_take |-> seq_tx_valid);
endmodule

// File: tb/qspi_regfront_tb.sv
// Bench: behavioural queue model stepped alongside the design, compared
// after every clock.
module qspi_regfront_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_we = 0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [11:0] seq_ctrl;
    logic [31:0] seq_total;
    logic [8:0]  seq_cmd_bytes;
    logic [3:0]  seq_idle_clks;
    logic        seq_start, seq_tx_valid;
    logic [7:0]  seq_tx_data;
    logic        s_take = 0, s_rpush = 0, s_rlast = 0, s_tdone = 0, s_ready = 1;
    logic [7:0]  s_rbyte = '0;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // model state
    byte unsigned tq[$];
    byte unsigned rq[$];
    logic [11:0] m_ctrl;
    logic [5:0]  m_ien;
    logic [15:0] m_hi, m_lo;
    logic [8:0]  m_cmd;
    logic [3:0]  m_idl;
    logic [3:0]  m_ev;   // {ovf, rxav, rxdone, txdone}
    logic        m_start;
    logic [31:0] m_rdata;

    always #2 clk = ~clk;

    qspi_regfront #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .seq_ctrl(seq_ctrl), .seq_total(seq_total),
        .seq_cmd_bytes(seq_cmd_bytes), .seq_idle_clks(seq_idle_clks),
        .seq_start(seq_start), .seq_tx_valid(seq_tx_valid),
        .seq_tx_data(seq_tx_data), .seq_tx_take(s_take),
        .seq_rx_push(s_rpush), .seq_rx_data(s_rbyte),
        .seq_rx_last(s_rlast), .seq_tx_done(s_tdone), .seq_ready(s_ready)
    );

    function automatic logic [9:0] mstat(input logic rdy);
        logic [9:0] s;
        s    = '0;
        s[0] = m_ev[0];
        s[1] = m_ev[1];
        s[2] = m_ev[2];
        s[3] = (tq.size() + 4 <= DEPTH);
        s[4] = (rq.size() == 0);
        s[5] = (tq.size() == DEPTH);
        s[7] = rdy;
        s[8] = m_ctrl[2];
        s[9] = m_ev[3];
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic mreset();
        tq.delete(); rq.delete();
        m_ctrl = '0; m_ien = '0; m_hi = '0; m_lo = '0; m_cmd = '0; m_idl = '0;
        m_ev = '0; m_start = 0; m_rdata = '0;
    endtask

    // one clock: advance model with the stimulus present, then compare
    task automatic cyc(input string tag);
        logic        wr, rd, tpop, pok;
        logic [4:0]  w;
        logic [3:0]  ev_n;
        logic [31:0] rv;
        int          rc, n;
        wr = bus_req && bus_we;
        rd = bus_req && !bus_we;
        w  = bus_addr[6:2];
        rv = m_rdata;
        rc = rq.size();
        if (rd) begin
            case (w)
                5'h00: rv = {20'h0, m_ctrl};
                5'h01: rv = {3'b0, m_idl, m_cmd, m_lo};
                5'h02: rv = {16'h0, m_hi};
                5'h03: rv = {26'h0, m_ien};
                5'h04: rv = {22'h0, mstat(s_ready)};
                5'h08: rv = (rc > 0) ? {24'h0, rq[0]} : 32'h0;
                5'h0A: begin
                    rv = 32'h0;
                    if (m_ctrl[2]) for (int k = 0; k < 4 && k < rc; k++) rv[8*k +: 8] = rq[k];
                end
                default: rv = 32'h0;
            endcase
        end
        ev_n = m_ev;
        if (wr && w == 5'h04) ev_n = ev_n & ~{bus_wdata[9], bus_wdata[2], bus_wdata[1], bus_wdata[0]};
        // TX
        tpop = s_take && tq.size() > 0;
        if (wr && w == 5'h09) begin
            if (tq.size() < DEPTH) tq.push_back(bus_wdata[7:0]); else ev_n[3] = 1;
        end
        if (wr && w == 5'h0B && m_ctrl[2]) begin
            if (tq.size() + 4 <= DEPTH) begin
                for (int k = 0; k < 4; k++) tq.push_back(bus_wdata[8*k +: 8]);
            end else ev_n[3] = 1;
        end
        if (tpop) void'(tq.pop_front());
        // RX
        n = 0;
        if (rd && w == 5'h08) n = (rc > 0) ? 1 : 0;
        if (rd && w == 5'h0A && m_ctrl[2]) n = (rc >= 4) ? 4 : rc;
        for (int k = 0; k < n; k++) void'(rq.pop_front());
        pok = s_rpush && rc < DEPTH;
        if (pok) rq.push_back(s_rbyte);
        if (pok && rc == 0) ev_n[2] = 1;
        if (pok && s_rlast) ev_n[1] = 1;
        if (s_tdone) ev_n[0] = 1;
        m_ev = ev_n;
        m_start = wr && w == 5'h01 && m_ctrl[0];
        if (wr && w == 5'h01) begin
            m_lo = bus_wdata[15:0]; m_cmd = bus_wdata[24:16]; m_idl = bus_wdata[28:25];
        end
        if (wr && w == 5'h00) m_ctrl = bus_wdata[11:0];
        if (wr && w == 5'h03) m_ien = bus_wdata[5:0];
        if (wr && w == 5'h02) m_hi = bus_wdata[15:0];
        m_rdata = rv;
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq", {31'h0, irq}, {31'h0, |(mstat(s_ready)[5:0] & m_ien)});
        chk("R3 start", {31'h0, seq_start}, {31'h0, m_start});
        chk("R3 frame", seq_total, {m_hi, m_lo});
        chk("R3 fields", {19'h0, seq_idle_clks, seq_cmd_bytes}, {19'h0, m_idl, m_cmd});
        chk("R2 ctrl out", {20'h0, seq_ctrl}, {20'h0, m_ctrl});
        chk("R12 valid", {31'h0, seq_tx_valid}, {31'h0, tq.size() > 0});
        if (tq.size() > 0) chk("R12 head", {24'h0, seq_tx_data}, {24'h0, tq[0]});
        if (rd) chk(tag, bus_rdata, m_rdata);
        bus_req = 0; bus_we = 0; s_take = 0; s_rpush = 0; s_rlast = 0; s_tdone = 0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        cyc(tag);
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        bus_req = 1; bus_we = 0; bus_addr = a;
        cyc(tag);
    endtask

    task automatic rxpush(input logic [7:0] b, input logic last);
        s_rpush = 1; s_rbyte = b; s_rlast = last;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    initial begin
        mreset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(7'h10, "R1 status after reset");
        rd(7'h00, "R1 ctrl after reset");
        // R2: register readback
        wr(7'h00, 32'hFFF_A5A, "R2");
        rd(7'h00, "R2 ctrl readback");
        wr(7'h0C, 32'hFFFF_FFFF, "R2");
        rd(7'h0C, "R2 ien readback");
        wr(7'h0C, 32'h0, "R2");
        wr(7'h08, 32'h0001_0002, "R2");
        rd(7'h08, "R2 hi readback");
        // R3: frame start disabled, then enabled
        wr(7'h00, 32'h000, "R3");
        wr(7'h04, 32'h1A05_0010, "R3 disabled");
        rd(7'h04, "R3 frame readback");
        wr(7'h00, 32'h003, "R3");
        wr(7'h04, 32'h0404_000A, "R3 enabled");
        cyc("R3 pulse end");
        // R7 / R12: byte TX, concurrent take and push
        wr(7'h24, 32'hFFFF_FF11, "R7");
        wr(7'h24, 32'h22, "R7");
        s_take = 1; wr(7'h24, 32'h33, "R12 take with push");
        for (int i = 0; i < 6; i++) wr(7'h24, 32'h40 + i, "R7 fill");
        rd(7'h10, "R4 status full");
        wr(7'h24, 32'h99, "R7 overflow");
        rd(7'h10, "R7 overflow bit");
        wr(7'h10, 32'h200, "R5 clear ovf");
        rd(7'h10, "R5 ovf cleared");
        while (tq.size() > 0) begin s_take = 1; cyc("R12 drain"); end
        // R8: packed TX
        wr(7'h2C, 32'hDDCC_BBAA, "R8 flag clear ignored");
        wr(7'h00, 32'h007, "R8");
        wr(7'h2C, 32'h4433_2211, "R8 packed");
        wr(7'h2C, 32'h8877_6655, "R8 packed");
        wr(7'h2C, 32'hCCBB_AA99, "R8 no space");
        rd(7'h10, "R8 overflow");
        s_take = 1; cyc("R8 order");
        s_take = 1; cyc("R8 order");
        while (tq.size() > 0) begin s_take = 1; cyc("R12 drain"); end
        // R11 / R6 / R9 / R10: RX side
        wr(7'h0C, 32'h06, "R6");
        rxpush(8'hA1, 0); cyc("R11 first push");
        rxpush(8'hA2, 0); cyc("R11");
        rxpush(8'hA3, 1); cyc("R11 last");
        rd(7'h10, "R11 status");
        rd(7'h20, "R9 byte read");
        rd(7'h28, "R10 packed partial");
        rd(7'h28, "R10 packed empty");
        rd(7'h20, "R9 empty read");
        wr(7'h10, 32'h006, "R5 clear");
        rxpush(8'hB1, 0); cyc("R11");
        wr(7'h00, 32'h003, "R10");
        rd(7'h28, "R10 flag clear");
        rd(7'h20, "R9");
        // R5: set wins over clear, same cycle
        rxpush(8'hC1, 1); wr(7'h10, 32'h007, "R5 collision");
        rd(7'h10, "R5 set wins");
        s_tdone = 1; wr(7'h10, 32'h001, "R5 txdone collision");
        wr(7'h0C, 32'h01, "R6");
        rd(7'h10, "R11 txdone");
        wr(7'h10, 32'h001, "R5");
        rd(7'h20, "R9");
        // mixed random run
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 11);
            s_ready = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0 && tq.size() > 0) s_take = 1;
            if ($urandom_range(0, 2) == 0 && rq.size() < DEPTH)
                rxpush(8'($urandom), $urandom_range(0, 3) == 0);
            if ($urandom_range(0, 9) == 0) s_tdone = 1;
            case (op)
                0: wr(7'h00, $urandom & 32'hFFF, "R2 mix");
                1: wr(7'h0C, $urandom, "R6 mix");
                2: wr(7'h10, $urandom, "R5 mix");
                3: wr(7'h24, $urandom, "R7 mix");
                4: wr(7'h2C, $urandom, "R8 mix");
                5: rd(7'h20, "R9 mix");
                6: rd(7'h28, "R10 mix");
                7: rd(7'h10, "R4 mix");
                8: wr(7'h04, $urandom, "R3 mix");
                9: wr(7'h00, {$urandom, 2'b11} & 32'hFFF, "R2 mix");
                default: cyc("R12 mix");
            endcase
        end
        finished = 1;
        summary();
    end
endmodule